// File: doc/BRIEF.md
# Watchdog register write-protection controller

This block is the write front end of a watchdog's configuration space. A simple write bus (strobe, 3-bit address, 8-bit data, plus a qualifier that marks a write as an unlock-key write) reaches seven 8-bit configuration registers through it. For every strobed write the block decides in the same cycle whether the data commits, is silently ignored, or is refused with a one-cycle bus error.

The registers fall into two groups. The primary group (main control, interrupt control, reset configuration, window configuration) can be frozen by a sticky lock bit held in the main control register. The auxiliary group (auxiliary control, interrupt flags, command) stays writable under lock, but then only through a timed unlock: a key write opens a short window that admits exactly one protected write. A protect-enable bit in main control applies the same timed unlock to all seven registers while the lock is clear. The watchdog enable bit, also in main control, can only be set by software, and it can still be set while the lock freezes everything else.

Top module: `wdt_wprot`

## Requirements
- R1: After synchronous reset all seven registers read 0x00.
- R2: With main control bit 1 (protect enable) and bit 7 (lock) both 0, a write to any address 0 to 6 commits on the next clock edge, with wr_ready high and wr_err low in the strobe cycle.
- R3: Writing 1 to main control bit 7 sets the lock; while it is set, writes to addresses 1, 2 and 3, even inside an unlock window, leave the register unchanged and raise wr_err.
- R4: The lock bit cannot be cleared by any write; only reset clears it.
- R5: Main control bit 0 (enable) is set-only: a committed main control write with data bit 0 at 0 leaves it at its old value.
- R6: While locked, a write to address 0 with data bit 0 at 1 sets the enable bit, leaves bits 7 to 1 unchanged and returns no error; with data bit 0 at 0 it changes nothing and raises wr_err.
- R7: While locked, writes to addresses 4, 5 and 6 raise wr_err and are dropped unless an unlock window is open, whatever the protect-enable bit; inside a window they commit.
- R8: With protect enable 1 and lock 0, a write to any of the seven registers outside an unlock window is dropped with wr_err.
- R9: A write with wr_key high and data 0xD8 opens an unlock window covering the four following cycles, with no error; a key write with any other data opens none and cancels any open window.
- R10: A window admits one committed protected write; the next protected write in what remains of it is refused.
- R11: A protected write in the fifth cycle after the key write is refused with wr_err.
- R12: wr_err is high only in the cycle of a strobed write, and wr_ready equals wr_en with wr_err low; an idle cycle gives both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_key | input | 1 | Marks the write as an unlock-key write (address ignored) |
| wr_addr | input | 3 | Register address, 0 to 6; 7 is reserved and ignored |
| wr_data | input | 8 | Write data |
| cfg_main | output | 8 | Main control: bit 0 enable, bit 1 protect enable, bit 7 lock |
| cfg_irq | output | 8 | Interrupt control register |
| cfg_rst | output | 8 | Reset configuration register |
| cfg_win | output | 8 | Window configuration register |
| cfg_aux | output | 8 | Auxiliary control register |
| irq_flags | output | 8 | Interrupt flag register |
| cmd_reg | output | 8 | Command register |
| wr_ready | output | 1 | Write accepted (committed or ignored) in this cycle |
| wr_err | output | 1 | Bus error for the write in this cycle |

## Verification
The closing of an unlock window and a protected write can land in the same cycle: the bench places a key write, three idle cycles and then a protected write in the fourth cycle, and expects it to commit, then repeats the pattern one cycle later and expects a refusal. A second collision is a write to a locked primary register while a window is open; it must be refused without spending the window, which the bench judges by a later auxiliary write in the same window committing only while the window is still alive. The set-only enable bit against a frozen main control register is judged by reading back every bit after a locked enable-set write.

// File: rtl/wdt_wprot_pkg.sv
package wdt_wprot_pkg;

  // bit positions inside the main control register
  localparam int EN_BIT   = 0;
  localparam int PROT_BIT = 1;
  localparam int LOCK_BIT = 7;

  // number of registers in the freezable primary group (addresses 0..NPRI-1)
  localparam int NPRI = 4;
  // total number of registers
  localparam int NREG = 7;

  typedef enum logic [1:0] {
    ACT_IGNORE = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_ENSET  = 2'd2,
    ACT_REJECT = 2'd3
  } wr_act_e;

endpackage

// File: rtl/wprot_unlock.sv
module wprot_unlock #(
  parameter int DW      = 8,
  parameter logic [DW-1:0] KEY = 8'hD8,
  parameter int WIN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  input  logic          consume,
  output logic          win_open
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (key_wr) begin
      cnt_q <= (key_data == KEY) ? CW'(WIN_CYC) : '0;
    end else if (consume) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign win_open = (cnt_q != '0);

  // R9: a correct key opens the window on the next cycle
  a_r9_key_opens: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_data == KEY) |=> win_open);

  // R10: a protected commit spends the window
  a_r10_single_use: assert property (@(posedge clk) disable iff (rst)
    (consume && !key_wr) |=> !win_open);

  // R11: the count never exceeds the window length
  a_r11_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(WIN_CYC));

endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wdt_wprot_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_key,
  input  logic [AW-1:0] wr_addr,
  input  logic          data_en,
  input  logic          lock,
  input  logic          prot,
  input  logic          win_open,
  output wr_act_e       act,
  output logic          consume,
  output logic          wr_err,
  output logic          wr_ready
);
  logic is_pri, is_sec, need_win;

  assign is_pri = (wr_addr < AW'(NPRI));
  assign is_sec = !is_pri && (wr_addr < AW'(NREG));

  always_comb begin
    act      = ACT_IGNORE;
    need_win = 1'b0;
    if (wr_en && !wr_key) begin
      if (is_pri) begin
        if (lock) begin
          act = (wr_addr == '0 && data_en) ? ACT_ENSET : ACT_REJECT;
        end else if (prot) begin
          need_win = 1'b1;
          act      = win_open ? ACT_COMMIT : ACT_REJECT;
        end else begin
          act = ACT_COMMIT;
        end
      end else if (is_sec) begin
        if (lock || prot) begin
          need_win = 1'b1;
          act      = win_open ? ACT_COMMIT : ACT_REJECT;
        end else begin
          act = ACT_COMMIT;
        end
      end
    end
  end

  assign consume  = (act == ACT_COMMIT) && need_win;
  assign wr_err   = (act == ACT_REJECT);
  assign wr_ready = wr_en && !wr_err;

  // R12: an error response only ever answers a strobed write
  a_r12_err_strobed: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> wr_en);

  // R7: with lock or protect enable, auxiliary commits need an open window
  a_r7_aux_needs_window: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_key && is_sec && (lock || prot) && !win_open) |-> wr_err);

endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
  import wdt_wprot_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  wr_act_e                  act,
  input  logic                     wr_en,
  input  logic                     wr_key,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs_q,
  output logic                     lock,
  output logic                     prot
);
  localparam logic [DW-1:0] STICKY = DW'((1 << EN_BIT) | (1 << LOCK_BIT));
  localparam logic [DW-1:0] EN_MSK = DW'(1 << EN_BIT);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = (act == ACT_COMMIT) && (wr_addr == AW'(i));
    if (i == 0) begin : g_main
      always_ff @(posedge clk) begin
        if (rst)                    regs_q[i] <= '0;
        else if (hit)               regs_q[i] <= wr_data | (regs_q[i] & STICKY);
        else if (act == ACT_ENSET)  regs_q[i] <= regs_q[i] | EN_MSK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      regs_q[i] <= '0;
        else if (hit) regs_q[i] <= wr_data;
      end
    end
  end

  assign lock = regs_q[0][LOCK_BIT];
  assign prot = regs_q[0][PROT_BIT];

  // R4: lock is sticky
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  // R5: enable is set-only
  a_r5_en_sticky: assert property (@(posedge clk) disable iff (rst)
    regs_q[0][EN_BIT] |=> regs_q[0][EN_BIT]);

  // R3: locked interrupt-control register does not move on a write
  a_r3_irq_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock && wr_en && !wr_key && wr_addr == AW'(1)) |=> $stable(regs_q[1]));

  // R6: a locked enable-set write only touches bit 0
  a_r6_enset_only: assert property (@(posedge clk) disable iff (rst)
    (lock && wr_en && !wr_key && wr_addr == '0 && wr_data[EN_BIT])
    |=> (regs_q[0][EN_BIT] && $stable(regs_q[0][DW-1:1])));

endmodule

// File: rtl/wdt_wprot.sv
module wdt_wprot
  import wdt_wprot_pkg::*;
#(
  parameter int DW      = 8,
  parameter logic [DW-1:0] KEY = 8'hD8,
  parameter int WIN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_key,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg_main,
  output logic [DW-1:0] cfg_irq,
  output logic [DW-1:0] cfg_rst,
  output logic [DW-1:0] cfg_win,
  output logic [DW-1:0] cfg_aux,
  output logic [DW-1:0] irq_flags,
  output logic [DW-1:0] cmd_reg,
  output logic          wr_ready,
  output logic          wr_err
);
  localparam int AW = 3;

  wr_act_e                  act;
  logic                     consume, win_open, lock, prot;
  logic [NREG-1:0][DW-1:0]  regs_q;

  wprot_unlock #(.DW(DW), .KEY(KEY), .WIN_CYC(WIN_CYC)) unlock_i (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_en && wr_key),
    .key_data (wr_data),
    .consume  (consume),
    .win_open (win_open)
  );

  wprot_decide #(.AW(AW)) decide_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_key   (wr_key),
    .wr_addr  (wr_addr),
    .data_en  (wr_data[EN_BIT]),
    .lock     (lock),
    .prot     (prot),
    .win_open (win_open),
    .act      (act),
    .consume  (consume),
    .wr_err   (wr_err),
    .wr_ready (wr_ready)
  );

  wprot_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .wr_en   (wr_en),
    .wr_key  (wr_key),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_q  (regs_q),
    .lock    (lock),
    .prot    (prot)
  );

  assign cfg_main  = regs_q[0];
  assign cfg_irq   = regs_q[1];
  assign cfg_rst   = regs_q[2];
  assign cfg_win   = regs_q[3];
  assign cfg_aux   = regs_q[4];
  assign irq_flags = regs_q[5];
  assign cmd_reg   = regs_q[6];

endmodule

// File: tb/wdt_wprot_tb_top.sv
`timescale 1ns/1ps
module wdt_wprot_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_key = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg_main, cfg_irq, cfg_rst, cfg_win, cfg_aux, irq_flags, cmd_reg;
  logic       wr_ready, wr_err;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_wprot dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_key(wr_key),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_main(cfg_main), .cfg_irq(cfg_irq), .cfg_rst(cfg_rst),
    .cfg_win(cfg_win), .cfg_aux(cfg_aux), .irq_flags(irq_flags),
    .cmd_reg(cmd_reg), .wr_ready(wr_ready), .wr_err(wr_err)
  );

  function automatic logic [7:0] rd(input logic [2:0] a);
    case (a)
      3'd0: rd = cfg_main;
      3'd1: rd = cfg_irq;
      3'd2: rd = cfg_rst;
      3'd3: rd = cfg_win;
      3'd4: rd = cfg_aux;
      3'd5: rd = irq_flags;
      3'd6: rd = cmd_reg;
      default: rd = 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // vector: {tag[3:0], we, wk, addr[2:0], data[7:0], xerr, chk_addr[2:0], chk_val[7:0]}
  localparam int NV = 36;
  localparam logic [1:0] W = 2'b10, K = 2'b11, I = 2'b00;
  localparam logic [28:0] VEC [NV] = '{
    {4'd2,  W, 3'd4, 8'h55, 1'b0, 3'd4, 8'h55},  // R2 free write aux
    {4'd2,  W, 3'd1, 8'h12, 1'b0, 3'd1, 8'h12},  // R2
    {4'd2,  W, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00},  // R2
    {4'd2,  W, 3'd0, 8'h01, 1'b0, 3'd0, 8'h01},  // R2 set enable
    {4'd5,  W, 3'd0, 8'h00, 1'b0, 3'd0, 8'h01},  // R5 enable kept
    {4'd2,  W, 3'd6, 8'h0F, 1'b0, 3'd6, 8'h0F},  // R2
    {4'd5,  W, 3'd0, 8'h02, 1'b0, 3'd0, 8'h03},  // R5 protect on, enable kept
    {4'd8,  W, 3'd2, 8'h33, 1'b1, 3'd2, 8'h00},  // R8
    {4'd8,  W, 3'd5, 8'h44, 1'b1, 3'd5, 8'h00},  // R8
    {4'd9,  K, 3'd0, 8'h11, 1'b0, 3'd0, 8'h03},  // R9 wrong key
    {4'd9,  W, 3'd2, 8'h33, 1'b1, 3'd2, 8'h00},  // R9 no window
    {4'd9,  K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h03},  // R9 key
    {4'd8,  W, 3'd2, 8'h33, 1'b0, 3'd2, 8'h33},  // R8 commit in window
    {4'd10, W, 3'd3, 8'h77, 1'b1, 3'd3, 8'h00},  // R10 window spent
    {4'd9,  K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h03},  // R9
    {4'd9,  I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h00},
    {4'd9,  I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h00},
    {4'd9,  I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h00},
    {4'd9,  W, 3'd3, 8'h77, 1'b0, 3'd3, 8'h77},  // R9 fourth cycle commits
    {4'd11, K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h03},  // R11
    {4'd11, I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h77},
    {4'd11, I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h77},
    {4'd11, I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h77},
    {4'd11, I, 3'd0, 8'h00, 1'b0, 3'd3, 8'h77},
    {4'd11, W, 3'd3, 8'h99, 1'b1, 3'd3, 8'h77},  // R11 fifth cycle refused
    {4'd3,  K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h03},  // R3
    {4'd3,  W, 3'd0, 8'h82, 1'b0, 3'd0, 8'h83},  // R3 set lock
    {4'd3,  W, 3'd1, 8'h55, 1'b1, 3'd1, 8'h12},  // R3 locked
    {4'd3,  K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h83},  // R3
    {4'd3,  W, 3'd1, 8'h55, 1'b1, 3'd1, 8'h12},  // R3 locked even in window
    {4'd4,  W, 3'd0, 8'h00, 1'b1, 3'd0, 8'h83},  // R4 lock not cleared
    {4'd7,  W, 3'd4, 8'h66, 1'b0, 3'd4, 8'h66},  // R7 window not spent by refusal
    {4'd7,  I, 3'd0, 8'h00, 1'b0, 3'd4, 8'h66},
    {4'd7,  W, 3'd5, 8'h21, 1'b1, 3'd5, 8'h00},  // R7 window gone
    {4'd7,  K, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h83},  // R7
    {4'd7,  W, 3'd5, 8'h21, 1'b0, 3'd5, 8'h21}   // R7 commit in window
  };

  task automatic op(input logic we, input logic wk, input logic [2:0] a,
                    input logic [7:0] d, input logic xe, input logic [2:0] ca,
                    input logic [7:0] cv, input string tag);
    @(negedge clk);
    wr_en = we; wr_key = wk; wr_addr = a; wr_data = d;
    #1;
    chk({tag, " err"}, {7'd0, wr_err}, {7'd0, xe});
    chk("R12 ready", {7'd0, wr_ready}, {7'd0, we & ~xe});
    @(negedge clk);
    wr_en = 1'b0; wr_key = 1'b0;
    #1;
    chk({tag, " value"}, rd(ca), cv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [28:0] v;
    logic [2:0]  pa;
    logic [7:0]  pv;
    int          ptag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    for (int a = 0; a < 7; a++) chk("R1 reset", rd(3'(a)), 8'h00);

    // table walk: one vector per cycle, value check lags by one cycle
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      if (i > 0) chk($sformatf("R%0d value v%0d", ptag, i - 1), rd(pa), pv);
      wr_en = v[24]; wr_key = v[23]; wr_addr = v[22:20]; wr_data = v[19:12];
      #1;
      chk($sformatf("R%0d err v%0d", int'(v[28:25]), i), {7'd0, wr_err}, {7'd0, v[11]});
      chk($sformatf("R12 ready v%0d", i), {7'd0, wr_ready}, {7'd0, v[24] & ~v[11]});
      pa = v[10:8]; pv = v[7:0]; ptag = int'(v[28:25]);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_key = 1'b0;
    chk($sformatf("R%0d value last", ptag), rd(pa), pv);

    // directed: reset clears lock and everything else
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    for (int a = 0; a < 7; a++) chk("R1 reset after lock", rd(3'(a)), 8'h00);
    chk("R12 idle err", {7'd0, wr_err}, 8'h00);
    chk("R12 idle ready", {7'd0, wr_ready}, 8'h00);

    // directed: lock without enable, then locked enable-set
    op(1'b1, 1'b0, 3'd0, 8'h80, 1'b0, 3'd0, 8'h80, "R3 lock only");
    op(1'b1, 1'b0, 3'd0, 8'h7F, 1'b0, 3'd0, 8'h81, "R6 enable set");
    op(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 3'd0, 8'h81, "R6 clear refused");
    op(1'b1, 1'b0, 3'd5, 8'h21, 1'b1, 3'd5, 8'h00, "R7 protect bit 0");
    op(1'b1, 1'b1, 3'd0, 8'hD8, 1'b0, 3'd0, 8'h81, "R9 key");
    op(1'b1, 1'b0, 3'd5, 8'h21, 1'b0, 3'd5, 8'h21, "R7 in window");
    op(1'b1, 1'b0, 3'd7, 8'h5A, 1'b0, 3'd0, 8'h81, "R12 reserved addr");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule